// File: doc/BRIEF.md
# I2C Controller Sticky Status Flags

This block keeps the event flags of an I2C controller. The protocol engine sends it single-cycle pulses, for example "a NACK came back" or "the byte count ran out". The block qualifies each pulse against the current mode and configuration levels and latches the result into a sticky bit of a read-only status word. The bit then stays set until one of its own clear paths removes it.

Six of the flags have a write-one-to-clear strobe. The two transfer-complete flags are different: they clear as a side effect of other control writes, namely loading a non-zero byte count, or requesting a START or a STOP. Disabling the peripheral, or pulsing the soft reset, empties the whole word.

An interrupt mask, written through the same data bus, selects which flags drive a single registered interrupt line.

Top module: `i2c_flag_stat`

## Requirements
- R1: The status word is 16 bits wide. The flags sit at fixed positions: overrun 10, arbitration lost 9, bus error 8, count-reload 7, transfer complete 6, stop seen 5, NACK 4, address match 3. Every other bit always reads 0.
- R2: An overrun pulse sets bit 10 only while the block is a slave (`is_master`=0) with `no_stretch`=1. In any other mode the pulse is ignored.
- R3: Arbitration-lost, misplaced start/stop and NACK pulses set bits 9, 8 and 4 in any mode. An address-match pulse sets bit 3 only while the block is a slave.
- R4: Bit 7 sets on a count-done pulse when `reload_mode`=1 and either `is_master`=1 or `slv_byte_ctl`=1. It clears when `wr_count` writes a non-zero `count_val`. A zero count leaves it set.
- R5: Bit 6 sets on a count-done pulse when `is_master`=1, `reload_mode`=0 and `auto_end`=0. It clears on `ctl_start` or `ctl_stop`.
- R6: Bit 5 sets on a stop pulse in two cases: as a master only when `own_stop`=1, and as a slave only when an address-match pulse was accepted after the previous stop pulse and before this one.
- R7: A `wr_clr` strobe clears each flag among bits 10, 9, 8, 5, 4 and 3 whose `wdata` bit is 1. Zero bits in `wdata` have no effect, and bits 7 and 6 are never cleared this way.
- R8: When a qualified set and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: After reset, and in the cycle after any cycle with `periph_en`=0 or `soft_rst`=1, the status word is 0. Events in those cycles are lost.
- R10: `wr_ien` loads `wdata` as an interrupt mask with the same bit positions. `irq` is a register equal to the OR of (status AND mask) as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; 0 holds every flag at 0 |
| soft_rst | input | 1 | Synchronous flag wipe |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| no_stretch | input | 1 | Clock stretching disabled |
| reload_mode | input | 1 | Byte count reload configured |
| auto_end | input | 1 | Automatic stop after count configured |
| slv_byte_ctl | input | 1 | Slave byte control enabled |
| own_stop | input | 1 | The pending stop was generated by this master |
| ev_overrun | input | 1 | Overrun/underrun pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_misplaced | input | 1 | Misplaced start or stop pulse |
| ev_count_done | input | 1 | Programmed byte count transferred |
| ev_stop | input | 1 | Stop condition seen on the bus |
| ev_nack | input | 1 | NACK received after a transmitted byte |
| ev_addr_match | input | 1 | Received address matched an enabled slave address |
| wr_clr | input | 1 | Write strobe of the clear register |
| wr_ien | input | 1 | Write strobe of the interrupt mask |
| wdata | input | 16 | Write data for the clear and mask strobes |
| wr_count | input | 1 | Write strobe of the byte count field |
| count_val | input | 8 | Byte count value being written |
| ctl_start | input | 1 | START request written |
| ctl_stop | input | 1 | STOP request written |
| status | output | 16 | Read-only status word |
| irq | output | 1 | Registered combined interrupt |

## Verification
Two things can hit the same flag in one cycle: a qualified event pulse that sets it, and a clear path that drops it. The clear path may be the clear register, a byte count write, or a START/STOP request. The random stimulus makes event pulses and clear strobes frequent and independent, so these collisions occur many times. Directed steps also force one collision on purpose: a NACK pulse arrives in the same cycle as a clear write that has bit 4 set. The bench judges every cycle against its own model, in which a set outweighs a clear, and the NACK case is also checked against a hand-written literal status value.

// File: rtl/i2c_flag_pkg.sv
`timescale 1ns/1ps
package i2c_flag_pkg;
  localparam int STAT_W = 16;
  localparam int NFLAG  = 8;
  localparam int TOP_B  = 10;
  localparam int LOW_B  = TOP_B - NFLAG + 1;

  // Index inside the 8-bit flag vector (bit 0 = status bit LOW_B)
  localparam int F_ADDR = 0;
  localparam int F_NACK = 1;
  localparam int F_STOP = 2;
  localparam int F_TC   = 3;
  localparam int F_TCR  = 4;
  localparam int F_BERR = 5;
  localparam int F_ARLO = 6;
  localparam int F_OVR  = 7;

  // Flags that the write-one-to-clear strobe may touch
  localparam logic [NFLAG-1:0] W1C_MASK = 8'b1110_0111;

  function automatic logic [STAT_W-1:0] place_flags(input logic [NFLAG-1:0] f);
    logic [STAT_W-1:0] w;
    w = '0;
    w[TOP_B -: NFLAG] = f;
    return w;
  endfunction

  function automatic logic [STAT_W-1:0] field_mask();
    return place_flags({NFLAG{1'b1}});
  endfunction
endpackage

// File: rtl/i2c_flag_cell.sv
`timescale 1ns/1ps
module i2c_flag_cell #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  generate
    if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (wipe)  q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
      end
    end else begin : g_clr_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (wipe)  q <= 1'b0;
        else if (clr_i) q <= 1'b0;
        else if (set_i) q <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/i2c_flag_qual.sv
`timescale 1ns/1ps
module i2c_flag_qual
  import i2c_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             is_master,
  input  logic             no_stretch,
  input  logic             reload_mode,
  input  logic             auto_end,
  input  logic             slv_byte_ctl,
  input  logic             own_stop,
  input  logic             ev_overrun,
  input  logic             ev_arb_lost,
  input  logic             ev_misplaced,
  input  logic             ev_count_done,
  input  logic             ev_stop,
  input  logic             ev_nack,
  input  logic             ev_addr_match,
  output logic [NFLAG-1:0] set_v
);
  logic addr_seen_q;
  logic addr_take;
  logic stop_take;

  assign addr_take = ev_addr_match & ~is_master;
  assign stop_take = ev_stop & (is_master ? own_stop : addr_seen_q);

  // Remembers that this slave was addressed since the last stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_seen_q <= 1'b0;
    else if (wipe) addr_seen_q <= 1'b0;
    else           addr_seen_q <= addr_take | (addr_seen_q & ~ev_stop);
  end

  always_comb begin
    set_v         = '0;
    set_v[F_OVR]  = ev_overrun & ~is_master & no_stretch;
    set_v[F_ARLO] = ev_arb_lost;
    set_v[F_BERR] = ev_misplaced;
    set_v[F_TCR]  = ev_count_done & reload_mode & (is_master | slv_byte_ctl);
    set_v[F_TC]   = ev_count_done & is_master & ~reload_mode & ~auto_end;
    set_v[F_STOP] = stop_take;
    set_v[F_NACK] = ev_nack;
    set_v[F_ADDR] = addr_take;
  end
endmodule

// File: rtl/i2c_flag_clr.sv
`timescale 1ns/1ps
module i2c_flag_clr
  import i2c_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             wr_clr,
  input  logic [NFLAG-1:0] clr_bits,
  input  logic             wr_count,
  input  logic [CNT_W-1:0] count_val,
  input  logic             ctl_start,
  input  logic             ctl_stop,
  output logic [NFLAG-1:0] clr_v
);
  logic count_nonzero;
  assign count_nonzero = |count_val;

  always_comb begin
    clr_v        = {NFLAG{wr_clr}} & clr_bits & W1C_MASK;
    clr_v[F_TCR] = wr_count & count_nonzero;
    clr_v[F_TC]  = ctl_start | ctl_stop;
  end
endmodule

// File: rtl/i2c_flag_irq.sv
`timescale 1ns/1ps
module i2c_flag_irq
  import i2c_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ien,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ien) mask_q <= wdata;
      irq <= |(status & mask_q);
    end
  end
endmodule

// File: rtl/i2c_flag_stat.sv
`timescale 1ns/1ps
module i2c_flag_stat
  import i2c_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_en,
  input  logic              soft_rst,
  input  logic              is_master,
  input  logic              no_stretch,
  input  logic              reload_mode,
  input  logic              auto_end,
  input  logic              slv_byte_ctl,
  input  logic              own_stop,
  input  logic              ev_overrun,
  input  logic              ev_arb_lost,
  input  logic              ev_misplaced,
  input  logic              ev_count_done,
  input  logic              ev_stop,
  input  logic              ev_nack,
  input  logic              ev_addr_match,
  input  logic              wr_clr,
  input  logic              wr_ien,
  input  logic [STAT_W-1:0] wdata,
  input  logic              wr_count,
  input  logic [CNT_W-1:0]  count_val,
  input  logic              ctl_start,
  input  logic              ctl_stop,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic             wipe;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] flag_q;

  assign wipe = ~periph_en | soft_rst;

  i2c_flag_qual u_qual (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .is_master(is_master), .no_stretch(no_stretch), .reload_mode(reload_mode),
    .auto_end(auto_end), .slv_byte_ctl(slv_byte_ctl), .own_stop(own_stop),
    .ev_overrun(ev_overrun), .ev_arb_lost(ev_arb_lost), .ev_misplaced(ev_misplaced),
    .ev_count_done(ev_count_done), .ev_stop(ev_stop), .ev_nack(ev_nack),
    .ev_addr_match(ev_addr_match), .set_v(set_v)
  );

  i2c_flag_clr #(.CNT_W(CNT_W)) u_clr (
    .wr_clr(wr_clr), .clr_bits(wdata[TOP_B -: NFLAG]),
    .wr_count(wr_count), .count_val(count_val),
    .ctl_start(ctl_start), .ctl_stop(ctl_stop), .clr_v(clr_v)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    i2c_flag_cell #(.SET_WINS(1'b1)) u_cell (
      .clk(clk), .rst_n(rst_n), .wipe(wipe),
      .set_i(set_v[i]), .clr_i(clr_v[i]), .q(flag_q[i])
    );
  end

  assign status = place_flags(flag_q);

  i2c_flag_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_ien(wr_ien), .wdata(wdata),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/i2c_flag_chk.sv
`timescale 1ns/1ps
module i2c_flag_chk
  import i2c_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              periph_en,
  input logic              soft_rst,
  input logic              is_master,
  input logic              no_stretch,
  input logic              own_stop,
  input logic              ev_overrun,
  input logic              ev_count_done,
  input logic              ev_stop,
  input logic              ev_nack,
  input logic              wr_clr,
  input logic [STAT_W-1:0] wdata,
  input logic              wr_count,
  input logic [CNT_W-1:0]  count_val,
  input logic              ctl_start,
  input logic              ctl_stop,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~field_mask()) == '0);

  p_ovr_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[10]) |-> $past(ev_overrun && !is_master && no_stretch));

  p_tcr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && !soft_rst && wr_count && count_val != '0 && !ev_count_done) |=> !status[7]);

  p_tc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && !soft_rst && (ctl_start || ctl_stop) && !ev_count_done) |=> !status[6]);

  p_stop_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[5]) && $past(is_master)) |-> $past(ev_stop && own_stop));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && !soft_rst && ev_nack && wr_clr && wdata[4]) |=> status[4]);

  p_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_en || soft_rst) |=> status == '0);

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(status != '0));
endmodule

bind i2c_flag_stat i2c_flag_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .soft_rst(soft_rst),
  .is_master(is_master), .no_stretch(no_stretch), .own_stop(own_stop),
  .ev_overrun(ev_overrun), .ev_count_done(ev_count_done), .ev_stop(ev_stop),
  .ev_nack(ev_nack), .wr_clr(wr_clr), .wdata(wdata), .wr_count(wr_count),
  .count_val(count_val), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
  .status(status), .irq(irq)
);

// File: tb/tb_i2c_flag_stat.sv
`timescale 1ns/1ps
module tb_i2c_flag_stat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_en, soft_rst, is_master, no_stretch, reload_mode, auto_end;
  logic slv_byte_ctl, own_stop;
  logic ev_overrun, ev_arb_lost, ev_misplaced, ev_count_done, ev_stop, ev_nack, ev_addr_match;
  logic wr_clr, wr_ien, wr_count, ctl_start, ctl_stop;
  logic [15:0] wdata;
  logic [7:0]  count_val;
  logic [15:0] status;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  // Bench model state
  logic [15:0] m_stat = '0;
  logic [15:0] m_mask = '0;
  logic        m_seen = 1'b0;

  always #2.5 clk = ~clk;

  i2c_flag_stat dut (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .soft_rst(soft_rst),
    .is_master(is_master), .no_stretch(no_stretch), .reload_mode(reload_mode),
    .auto_end(auto_end), .slv_byte_ctl(slv_byte_ctl), .own_stop(own_stop),
    .ev_overrun(ev_overrun), .ev_arb_lost(ev_arb_lost), .ev_misplaced(ev_misplaced),
    .ev_count_done(ev_count_done), .ev_stop(ev_stop), .ev_nack(ev_nack),
    .ev_addr_match(ev_addr_match), .wr_clr(wr_clr), .wr_ien(wr_ien), .wdata(wdata),
    .wr_count(wr_count), .count_val(count_val), .ctl_start(ctl_start),
    .ctl_stop(ctl_stop), .status(status), .irq(irq)
  );

  // Next status word, written from the requirements (set outweighs clear)
  function automatic logic [15:0] model_next();
    logic [15:0] s, c;
    s = '0; c = '0;
    if (!periph_en || soft_rst) return 16'h0000;          // R9
    s[10] = ev_overrun && !is_master && no_stretch;       // R2
    s[9]  = ev_arb_lost;                                  // R3
    s[8]  = ev_misplaced;
    s[4]  = ev_nack;
    s[3]  = ev_addr_match && !is_master;
    s[7]  = ev_count_done && reload_mode && (is_master || slv_byte_ctl); // R4
    s[6]  = ev_count_done && is_master && !reload_mode && !auto_end;     // R5
    s[5]  = ev_stop && (is_master ? own_stop : m_seen);                  // R6
    if (wr_clr) c = wdata & 16'b0000_0111_0011_1000;      // R7
    if (wr_count && count_val != 8'd0) c[7] = 1'b1;
    if (ctl_start || ctl_stop) c[6] = 1'b1;
    return (m_stat & ~c) | s;                             // R8
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ev_overrun = 0; ev_arb_lost = 0; ev_misplaced = 0; ev_count_done = 0;
    ev_stop = 0; ev_nack = 0; ev_addr_match = 0;
    wr_clr = 0; wr_ien = 0; wr_count = 0; ctl_start = 0; ctl_stop = 0;
    wdata = '0; count_val = '0; soft_rst = 0;
  endtask

  // One clock: model the edge, then compare status and irq
  task automatic tick(input string req);
    logic [15:0] n_stat;
    logic        n_irq;
    logic        n_seen;
    n_stat = model_next();
    n_irq  = |(m_stat & m_mask);
    if (!periph_en || soft_rst) n_seen = 1'b0;
    else n_seen = (ev_addr_match && !is_master) || (m_seen && !ev_stop);
    @(posedge clk);
    if (wr_ien) m_mask = wdata;
    @(negedge clk);
    m_stat = n_stat;
    m_seen = n_seen;
    check(req, status, n_stat);
    check({req, " irq R10"}, {15'd0, irq}, {15'd0, n_irq});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle();
    periph_en = 1; is_master = 1; no_stretch = 0; reload_mode = 0;
    auto_end = 0; slv_byte_ctl = 0; own_stop = 0;
    repeat (3) @(negedge clk);
    check("R9 reset status", status, 16'h0000);
    check("R9 reset irq", {15'd0, irq}, 16'h0000);
    rst_n = 1;
    @(negedge clk);

    // R2: overrun ignored in master mode, taken in slave no-stretch
    ev_overrun = 1; tick("R2 master"); idle();
    check("R2 master ignored", status, 16'h0000);
    is_master = 0; no_stretch = 0; ev_overrun = 1; tick("R2 stretch"); idle();
    check("R2 stretch ignored", status, 16'h0000);
    no_stretch = 1; ev_overrun = 1; tick("R2 slave"); idle();
    check("R2 slave set", status, 16'h0400);

    // R8: NACK pulse together with clear of bit 4
    ev_nack = 1; wr_clr = 1; wdata = 16'h0010; tick("R8 collide"); idle();
    check("R8 set wins", status, 16'h0410);

    // R7: zero clear has no effect, ones clear
    wr_clr = 1; wdata = 16'h0000; tick("R7 zero"); idle();
    check("R7 zero write", status, 16'h0410);
    wr_clr = 1; wdata = 16'h0400; tick("R7 one"); idle();
    check("R7 partial", status, 16'h0010);

    // R3: unconditional sets, address only as slave
    ev_arb_lost = 1; ev_misplaced = 1; tick("R3 set"); idle();
    check("R3 arlo berr", status, 16'h0310);
    is_master = 1; ev_addr_match = 1; tick("R3 addr master"); idle();
    check("R3 addr ignored in master", status, 16'h0310);
    wr_clr = 1; wdata = 16'hFFFF; tick("R7 all"); idle();
    check("R7 clear all", status, 16'h0000);

    // R4: count-reload
    reload_mode = 1; ev_count_done = 1; tick("R4 set"); idle();
    check("R4 set", status, 16'h0080);
    wr_count = 1; count_val = 8'd0; tick("R4 zero"); idle();
    check("R4 zero count keeps", status, 16'h0080);
    wr_clr = 1; wdata = 16'hFFFF; tick("R7 tcr"); idle();
    check("R7 no w1c on bit7", status, 16'h0080);
    wr_count = 1; count_val = 8'd5; tick("R4 clear"); idle();
    check("R4 nonzero clears", status, 16'h0000);

    // R5: transfer complete
    reload_mode = 0; ev_count_done = 1; tick("R5 set"); idle();
    check("R5 set", status, 16'h0040);
    ctl_stop = 1; tick("R5 clear"); idle();
    check("R5 stop clears", status, 16'h0000);

    // R6: stop qualification
    own_stop = 0; ev_stop = 1; tick("R6 foreign"); idle();
    check("R6 master foreign stop", status, 16'h0000);
    is_master = 0; ev_stop = 1; tick("R6 slave unaddr"); idle();
    check("R6 slave not addressed", status, 16'h0000);
    ev_addr_match = 1; tick("R6 addr"); idle();
    ev_stop = 1; tick("R6 slave stop"); idle();
    check("R6 slave addressed", status, 16'h0028);

    // R10: mask then irq one cycle later
    wr_ien = 1; wdata = 16'h0020; tick("R10 mask"); idle();
    tick("R10 irq");
    check("R10 irq high", {15'd0, irq}, 16'h0001);

    // R9: soft reset beats an event
    soft_rst = 1; ev_nack = 1; tick("R9 soft"); idle();
    check("R9 soft reset", status, 16'h0000);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      if ((k % 64) == 0) begin
        is_master = $urandom_range(1); no_stretch = $urandom_range(1);
        reload_mode = $urandom_range(1); auto_end = $urandom_range(1);
        slv_byte_ctl = $urandom_range(1);
      end
      periph_en     = ($urandom_range(31) != 0);
      soft_rst      = ($urandom_range(40) == 0);
      own_stop      = $urandom_range(1);
      ev_overrun    = ($urandom_range(3) == 0);
      ev_arb_lost   = ($urandom_range(5) == 0);
      ev_misplaced  = ($urandom_range(5) == 0);
      ev_count_done = ($urandom_range(3) == 0);
      ev_stop       = ($urandom_range(4) == 0);
      ev_nack       = ($urandom_range(3) == 0);
      ev_addr_match = ($urandom_range(3) == 0);
      wr_clr        = ($urandom_range(3) == 0);
      wr_ien        = ($urandom_range(15) == 0);
      wdata         = 16'($urandom);
      wr_count      = ($urandom_range(4) == 0);
      count_val     = ($urandom_range(1) == 0) ? 8'd0 : 8'($urandom);
      ctl_start     = ($urandom_range(6) == 0);
      ctl_stop      = ($urandom_range(6) == 0);
      tick("R1-mix random R8");
    end
    idle(); periph_en = 1;
    tick("R1 settle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule